// File: doc/BRIEF.md
# Cascadable Loadable Binary Counter Chain

This block is a synchronous binary counter assembled from a parameterised number of equal 4-bit stages. Each stage keeps its own value, advances when both of its count enables are high, takes a preset value when the shared load control is low, and otherwise holds. It also produces a look-ahead terminal count that feeds the trickle enable of the next, more significant stage.

The parallel enable, the load control and the clock go to every stage. The trickle enable enters only the least significant stage. Only the trickle path gates the terminal count, so the chain needs no carry logic beyond the stages themselves.

An active-low master reset clears the whole chain at once, without waiting for a clock edge. The chain-level carry output can enable a further chain, provided the receiving logic samples it on the clock.

Top module: `seg_counter_chain`

## Requirements
- R1: While `rst_n` is low, `count` and `carry_out` are 0. Reset takes effect at once, without a clock edge, and overrides every other input.
- R2: If `load_n` is low at a rising edge (with `rst_n` high), `count` takes the value of `preset` at that edge, whatever the levels of `en_par` and `en_trk`.
- R3: If `load_n`, `en_par` and `en_trk` are all high at a rising edge, `count` increases by exactly one, modulo 2^(4*N_STAGES). Each 4-bit stage advances only when every less significant stage is at 15.
- R4: If `load_n` is high and either `en_par` or `en_trk` is low at a rising edge, `count` keeps its value.
- R5: `carry_out` is combinational and equals `en_trk` AND every bit of `count`. It is high only at the all-ones value while `en_trk` is high.
- R6: A count step from the all-ones value wraps `count` to 0.
- R7: `carry_out` does not depend on `en_par` or `load_n`. At the all-ones value with `en_trk` high, it is high even when `en_par` is low or `load_n` is low.
- R8: The stages are laid out least significant first: `count[3:0]` is stage 0, which receives `en_trk`, and bits `[4k+3:4k]` belong to stage k. The 4*N_STAGES-bit `preset` word is loaded into all stages in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes except reset occur on its rising edge |
| rst_n | input | 1 | Active-low asynchronous master reset |
| load_n | input | 1 | Active-low synchronous load control for all stages |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_trk | input | 1 | Trickle count enable into the least significant stage |
| preset | input | 4*N_STAGES | Parallel preset word |
| count | output | 4*N_STAGES | Current counter value |
| carry_out | output | 1 | Terminal count of the most significant stage |

## Verification
The hardest case to reach from the ports is reset going low between two clock edges while the chain is busy. Here the value has to clear before any edge arrives, and the following edges must not count. The bench pulses reset in the middle of a cycle at random points of a long random sequence. It checks for zero one nanosecond after the fall and again after an edge taken under reset.

The other hard case is the upper stage's trickle path at the all-ones value under every enable pattern. The bench reaches it by loading every 8-bit value and then applying all four enable combinations in turn.

// File: rtl/cnt_chain_pkg.sv
`timescale 1ns/1ps
package cnt_chain_pkg;

   localparam int unsigned STAGE_BITS = 4;

   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,
      ST_COUNT = 2'd1,
      ST_LOAD  = 2'd2
   } stage_op_e;

   function automatic stage_op_e pick_op(input logic load, input logic par_ok, input logic trk);
      if (load)
         return ST_LOAD;
      else if (par_ok && trk)
         return ST_COUNT;
      else
         return ST_HOLD;
   endfunction

endpackage

// File: rtl/cnt_mode_dec.sv
`timescale 1ns/1ps
module cnt_mode_dec (
   input  logic load_n,
   input  logic en_par,
   output logic load,
   output logic par_ok
);
   // load wins over both enables; par_ok only matters when not loading
   assign load   = ~load_n;
   assign par_ok = load_n & en_par;
endmodule

// File: rtl/cnt_stage.sv
`timescale 1ns/1ps
module cnt_stage
   import cnt_chain_pkg::*;
#(
   parameter int unsigned SW = STAGE_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          par_ok,
   input  logic          trk_in,
   input  logic [SW-1:0] d,
   output logic [SW-1:0] q,
   output logic          tc
);
   localparam logic [SW-1:0] ONE = SW'(1);

   stage_op_e     op;
   logic [SW-1:0] q_nxt;

   always_comb begin
      op = pick_op(load, par_ok, trk_in);
      unique case (op)
         ST_LOAD:  q_nxt = d;
         ST_COUNT: q_nxt = q + ONE;
         default:  q_nxt = q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else
         q <= q_nxt;
   end

   // look-ahead terminal count: gated by trickle enable only
   assign tc = trk_in & (&q);
endmodule

// File: rtl/seg_counter_chain.sv
`timescale 1ns/1ps
module seg_counter_chain
   import cnt_chain_pkg::*;
#(
   parameter int unsigned N_STAGES = 2,
   parameter int unsigned SW       = STAGE_BITS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_n,
   input  logic                   en_par,
   input  logic                   en_trk,
   input  logic [N_STAGES*SW-1:0] preset,
   output logic [N_STAGES*SW-1:0] count,
   output logic                   carry_out
);
   localparam int unsigned CNT_W = N_STAGES * SW;

   generate
      if (N_STAGES < 1) begin : g_bad_stages
         $error("seg_counter_chain: N_STAGES must be at least 1");
      end
      if (SW < 1) begin : g_bad_width
         $error("seg_counter_chain: SW must be at least 1");
      end
   endgenerate

   logic             load;
   logic             par_ok;
   logic [N_STAGES:0] trk;

   cnt_mode_dec u_dec (
      .load_n (load_n),
      .en_par (en_par),
      .load   (load),
      .par_ok (par_ok)
   );

   assign trk[0] = en_trk;

   generate
      for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
         cnt_stage #(.SW(SW)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .par_ok (par_ok),
            .trk_in (trk[i]),
            .d      (preset[i*SW +: SW]),
            .q      (count[i*SW +: SW]),
            .tc     (trk[i+1])
         );
      end
   endgenerate

   assign carry_out = trk[N_STAGES];

   initial begin
      if (CNT_W != N_STAGES * SW)
         $error("seg_counter_chain: width mismatch");
   end
endmodule

// File: rtl/seg_counter_chain_chk.sv
`timescale 1ns/1ps
module seg_counter_chain_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_n,
   input logic             en_par,
   input logic             en_trk,
   input logic [CNT_W-1:0] preset,
   input logic [CNT_W-1:0] count,
   input logic             carry_out
);
   AST_RESET_CLEARS: assert property (@(negedge clk) !rst_n |-> (count == '0 && !carry_out)); // R1

   AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !load_n) |=> count == $past(preset)); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && load_n && en_par && en_trk) |=> count == CNT_W'($past(count) + 1'b1)); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && load_n && !(en_par && en_trk)) |=> $stable(count)); // R4

   AST_CARRY_MATCH: assert property (@(negedge clk) disable iff (!rst_n)
      carry_out == (en_trk && (&count))); // R5

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && load_n && en_par && en_trk && (&count)) |=> count == '0); // R6
endmodule

bind seg_counter_chain seg_counter_chain_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_n    (load_n),
   .en_par    (en_par),
   .en_trk    (en_trk),
   .preset    (preset),
   .count     (count),
   .carry_out (carry_out)
);

// File: tb/tb_seg_counter_chain.sv
`timescale 1ns/1ps
module tb_seg_counter_chain;
   localparam int W   = 8;
   localparam int MOD = 256;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic         load_n = 1'b1;
   logic         en_par = 1'b0;
   logic         en_trk = 1'b0;
   logic [W-1:0] preset = '0;
   logic [W-1:0] count;
   logic         carry_out;

   int  errs = 0;
   int  checks = 0;
   int  m = 0;
   bit  done = 1'b0;

   seg_counter_chain #(.N_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par),
      .en_trk(en_trk), .preset(preset), .count(count), .carry_out(carry_out)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // one rising edge; model follows the inputs seen at the edge
   task automatic tick();
      @(posedge clk);
      if (rst_n) begin
         if (!load_n) m = int'(preset);
         else if (en_par && en_trk) m = (m + 1) % MOD;
      end
      #1;
   endtask

   task automatic chk_carry(input string req);
      #0.5;
      chk(carry_out == (en_trk && m == MOD-1), req, int'(carry_out), int'(en_trk && m == MOD-1));
   endtask

   task automatic mid_reset();
      rst_n = 1'b0;
      #1;
      chk(count == '0 && !carry_out, "R1 async clear", int'(count), 0);
      m = 0;
      tick();
      chk(count == '0, "R1 edge under reset", int'(count), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      #1;
      rst_n = 1'b0;
      #1;
      chk(count == '0, "R1 reset count", int'(count), 0);
      chk(carry_out == 1'b0, "R1 reset carry", int'(carry_out), 0);
      tick(); tick();
      rst_n = 1'b1;
      m = 0;

      // exhaustive preset sweep with every enable pattern
      for (int v = 0; v < MOD; v++) begin
         load_n = 1'b0;
         preset = W'(v);
         en_par = v[0];
         en_trk = v[1];
         if (v == MOD-1) begin
            en_trk = 1'b1;
            chk_carry("R7 carry while loading");
         end
         tick();
         chk(int'(count) == v, "R2 R8 load whole word", int'(count), v);
         load_n = 1'b1;
         preset = ~W'(v);
         for (int c = 0; c < 4; c++) begin
            en_par = c[0];
            en_trk = c[1];
            chk_carry(m == MOD-1 ? "R7 carry independent of en_par" : "R5 carry");
            tick();
            if (c == 3)
               chk(int'(count) == m, (v == MOD-1) ? "R6 wrap" : "R3 count step", int'(count), m);
            else
               chk(int'(count) == m, "R4 hold", int'(count), m);
         end
      end

      // long run across stage boundary and wrap
      load_n = 1'b0; preset = 8'hF0; tick();
      load_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
      for (int k = 0; k < 300; k++) begin
         tick();
         chk(int'(count) == m, "R3 R8 cascade run", int'(count), m);
         chk(count[3:0] == 4'(m % 16), "R8 low stage bits", int'(count[3:0]), m % 16);
         chk_carry("R5 carry in run");
      end

      // random sequences with mid-cycle resets
      for (int k = 0; k < 2000; k++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 2) begin
            mid_reset();
         end else begin
            load_n = (r < 12) ? 1'b0 : 1'b1;
            en_par = ($urandom_range(0, 3) != 0);
            en_trk = ($urandom_range(0, 3) != 0);
            preset = W'($urandom_range(0, MOD-1));
            if (r > 90) preset = 8'hFE;
            chk_carry("R5 R7 random carry");
            tick();
            chk(int'(count) == m, "R2 R3 R4 random", int'(count), m);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule